// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs one non-volatile array operation each time software pulses `start`. It takes the operation code, the target address, a data word and an SRAM source address, and checks the write-protect bit of the target page. If the page is free, it issues the array commands for the operation. The four operations are: program one word from the data input; program one row of 128 words fetched from an SRAM buffer; erase one 4096-byte page; and erase the whole program area. The array is addressed in rows of 128 words, and eight rows make one page. A page is the smallest unit that can be erased.

Each array command is held until the array shows it is not busy. The array then raises `fa_busy` for the length of the program or erase. The sequencer waits for `fa_busy` to fall before it moves on. When the operation ends, `done_evt` pulses for one cycle and a sticky completion flag is set for an interrupt controller to read. Errors are reported in two flags. A protection violation and a low-voltage event seen during the operation both mark the operation as failed. While an operation runs, a request to enter a low-power state is held back.

Top module: `flash_op_seq`

## Requirements
- R1: With `op_sel` = 2'b00 (word program), exactly one `fa_prog` command is issued. Its address is `tgt_addr` with the two low bits cleared, and its data is `wdata`.
- R2: With `op_sel` = 2'b01 (row program), 128 `fa_prog` commands are issued. Command i goes to the row base plus 4*i, where the row base is `tgt_addr` with bits [8:0] cleared. Command i carries the SRAM word returned for address (`src_addr` with bits [1:0] cleared) + 4*i. Each command is issued only after its `sram_rvalid`.
- R3: With `op_sel` = 2'b10 (page erase), exactly one `fa_erase_pg` command is issued, at `tgt_addr` with bits [11:0] cleared.
- R4: With `op_sel` = 2'b11 (whole-area erase), exactly one `fa_erase_all` command is issued, with `fa_addr` = 0 whatever the target address.
- R5: The page index is `tgt_addr` bits [12 +: log2(NUM_PAGES)]. If `wp_page` is set for that page, the word program, row program and page erase issue no command. The whole-area erase issues none if any `wp_page` bit is set. A refused operation still completes, with `wr_err` = 1.
- R6: `busy` is high from the cycle after an accepted `start` through the completion cycle. `start` is ignored while `busy` is high.
- R7: `done_evt` is high for exactly the last busy cycle. `done_flag` is set in the following cycle and stays set until `flag_clr`. When completion and `flag_clr` fall in the same cycle, the set wins.
- R8: If `lv_detect` is high in any busy cycle, both `lv_err` and `wr_err` are set. The operation still runs to its end.
- R9: `wr_err` and `lv_err` are cleared when the next `start` is accepted.
- R10: `sleep_ack` follows `sleep_req` only while `busy` is low. A request made during an operation is granted after completion.
- R11: At most one array command is asserted at a time. A command seen with `fa_busy` high is held, with the same address, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for one operation |
| op_sel | input | 2 | 00 word, 01 row, 10 page erase, 11 whole erase |
| tgt_addr | input | AW | Target array byte address |
| wdata | input | DW | Data for word program |
| src_addr | input | AW | SRAM byte address of row buffer |
| wp_page | input | NUM_PAGES | Per-page write-protect |
| lv_detect | input | 1 | Low-voltage indication |
| sleep_req | input | 1 | Request to enter low-power state |
| flag_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Operation in progress |
| done_evt | output | 1 | One-cycle completion event |
| done_flag | output | 1 | Sticky completion flag |
| wr_err | output | 1 | Operation failed |
| lv_err | output | 1 | Low voltage seen during operation |
| sleep_ack | output | 1 | Low-power entry granted |
| sram_req | output | 1 | SRAM read request |
| sram_addr | output | AW | SRAM read address |
| sram_rvalid | input | 1 | SRAM read data valid |
| sram_rdata | input | DW | SRAM read data |
| fa_prog | output | 1 | Array program-word command |
| fa_erase_pg | output | 1 | Array page-erase command |
| fa_erase_all | output | 1 | Array whole-area erase command |
| fa_addr | output | AW | Array command address |
| fa_wdata | output | DW | Array program data |
| fa_busy | input | 1 | Array busy; command accepted while low |

## Verification
Two actions can land in the same cycle: the completion, which sets the sticky flag, and software clearing that flag. The bench drives `flag_clr` in exactly the cycle where it sees `done_evt`, then checks that `done_flag` reads one afterwards. A separate pulse of `flag_clr` alone shows that the clear works. A second collision is a `start` pulse during the completion cycle. The bench checks that `busy` is low afterwards and that no extra array command appears. Sweeping every page against every protect mask with word programs checks the page-index decode against arithmetic done in the bench.

// File: rtl/flash_op_seq.sv
module flash_op_seq #(
  parameter int AW            = 32,
  parameter int DW            = 32,
  parameter int ROW_WORDS     = 128,
  parameter int ROWS_PER_PAGE = 8,
  parameter int NUM_PAGES     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           op_sel,
  input  logic [AW-1:0]        tgt_addr,
  input  logic [DW-1:0]        wdata,
  input  logic [AW-1:0]        src_addr,
  input  logic [NUM_PAGES-1:0] wp_page,
  input  logic                 lv_detect,
  input  logic                 sleep_req,
  input  logic                 flag_clr,
  output logic                 busy,
  output logic                 done_evt,
  output logic                 done_flag,
  output logic                 wr_err,
  output logic                 lv_err,
  output logic                 sleep_ack,
  output logic                 sram_req,
  output logic [AW-1:0]        sram_addr,
  input  logic                 sram_rvalid,
  input  logic [DW-1:0]        sram_rdata,
  output logic                 fa_prog,
  output logic                 fa_erase_pg,
  output logic                 fa_erase_all,
  output logic [AW-1:0]        fa_addr,
  output logic [DW-1:0]        fa_wdata,
  input  logic                 fa_busy
);
  localparam int BSH    = $clog2(DW / 8);
  localparam int IDX_W  = $clog2(ROW_WORDS);
  localparam int ROW_LSB = IDX_W + BSH;
  localparam int PG_LSB = ROW_LSB + $clog2(ROWS_PER_PAGE);
  localparam int PG_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int QW     = AW - BSH;

  localparam logic [1:0] OP_WORD = 2'b00, OP_ROW = 2'b01, OP_PAGE = 2'b10, OP_ALL = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_RDW, S_ISSUE, S_SETTLE, S_WAIT, S_FIN} st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic [QW-1:0]    addr_q;
  logic [QW-1:0]    src_q;
  logic [DW-1:0]    data_q;
  logic [IDX_W-1:0] idx;
  logic             prot;
  logic             last_word;
  logic [PG_W-1:0]  pg;
  logic             unused_low;

  assign unused_low = ^{tgt_addr[BSH-1:0], src_addr[BSH-1:0]};
  assign pg        = addr_q[PG_LSB-BSH +: PG_W];
  assign prot      = (op_q == OP_ALL) ? (|wp_page) : wp_page[pg];
  assign last_word = (op_q != OP_ROW) || (idx == IDX_W'(ROW_WORDS - 1));

  assign busy      = (st != S_IDLE);
  assign done_evt  = (st == S_FIN);
  assign sleep_ack = sleep_req && !busy;
  assign sram_req  = (st == S_RD);
  assign sram_addr = {src_q + QW'(idx), {BSH{1'b0}}};

  assign fa_prog      = (st == S_ISSUE) && (op_q == OP_WORD || op_q == OP_ROW);
  assign fa_erase_pg  = (st == S_ISSUE) && (op_q == OP_PAGE);
  assign fa_erase_all = (st == S_ISSUE) && (op_q == OP_ALL);
  assign fa_wdata     = data_q;

  always_comb begin
    case (op_q)
      OP_WORD: fa_addr = {addr_q, {BSH{1'b0}}};
      OP_ROW:  fa_addr = {addr_q[QW-1:ROW_LSB-BSH], idx, {BSH{1'b0}}};
      OP_PAGE: fa_addr = {addr_q[QW-1:PG_LSB-BSH], {PG_LSB{1'b0}}};
      default: fa_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_WORD;
      addr_q <= '0;
      src_q  <= '0;
      data_q <= '0;
      idx    <= '0;
      wr_err <= 1'b0;
      lv_err <= 1'b0;
    end else begin
      if (busy && lv_detect) begin
        wr_err <= 1'b1;
        lv_err <= 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op_sel;
          addr_q <= tgt_addr[AW-1:BSH];
          src_q  <= src_addr[AW-1:BSH];
          data_q <= wdata;
          idx    <= '0;
          wr_err <= 1'b0;
          lv_err <= 1'b0;
          st     <= S_CHECK;
        end
        S_CHECK: begin
          if (prot) begin
            wr_err <= 1'b1;
            st     <= S_FIN;
          end else begin
            st <= (op_q == OP_ROW) ? S_RD : S_ISSUE;
          end
        end
        S_RD:  st <= S_RDW;
        S_RDW: if (sram_rvalid) begin
          data_q <= sram_rdata;
          st     <= S_ISSUE;
        end
        S_ISSUE:  if (!fa_busy) st <= S_SETTLE;
        S_SETTLE: st <= S_WAIT;
        S_WAIT: if (!fa_busy) begin
          if (last_word) st <= S_FIN;
          else begin
            idx <= idx + 1'b1;
            st  <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_flag <= 1'b0;
    else if (st == S_FIN)  done_flag <= 1'b1;
    else if (flag_clr)     done_flag <= 1'b0;
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && done_flag));                                            // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fa_prog || fa_erase_pg || fa_erase_all || sram_req));              // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);                                       // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);                                                       // R7
  AST_LV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lv_detect) |=> (lv_err && wr_err));                                   // R8
  AST_SLEEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> !busy);                                                          // R10
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fa_prog, fa_erase_pg, fa_erase_all}));                               // R11
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((fa_prog || fa_erase_pg || fa_erase_all) && fa_busy) |=>
      ((fa_prog || fa_erase_pg || fa_erase_all) && $stable(fa_addr)));             // R11
endmodule

// File: tb/flash_op_seq_tb.sv
`timescale 1ns/1ps
module flash_op_seq_tb;
  localparam int NP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 0, lv_detect = 0, sleep_req = 0, flag_clr = 0;
  logic [1:0]  op_sel = 0;
  logic [31:0] tgt_addr = 0, wdata = 0, src_addr = 0;
  logic [NP-1:0] wp_page = 0;
  logic busy, done_evt, done_flag, wr_err, lv_err, sleep_ack, sram_req;
  logic [31:0] sram_addr, fa_addr, fa_wdata;
  logic sram_rvalid = 0, fa_busy = 0;
  logic [31:0] sram_rdata = 0;
  logic fa_prog, fa_erase_pg, fa_erase_all;

  flash_op_seq #(.NUM_PAGES(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .tgt_addr(tgt_addr),
    .wdata(wdata), .src_addr(src_addr), .wp_page(wp_page), .lv_detect(lv_detect),
    .sleep_req(sleep_req), .flag_clr(flag_clr), .busy(busy), .done_evt(done_evt),
    .done_flag(done_flag), .wr_err(wr_err), .lv_err(lv_err), .sleep_ack(sleep_ack),
    .sram_req(sram_req), .sram_addr(sram_addr), .sram_rvalid(sram_rvalid),
    .sram_rdata(sram_rdata), .fa_prog(fa_prog), .fa_erase_pg(fa_erase_pg),
    .fa_erase_all(fa_erase_all), .fa_addr(fa_addr), .fa_wdata(fa_wdata), .fa_busy(fa_busy));

  function automatic logic [31:0] sram_fn(input logic [31:0] a);
    return (a ^ 32'h5EED_0000) + 32'd7;
  endfunction

  int errors = 0, checks = 0, cyc = 0;

  // SRAM model with varying latency
  logic s_pend = 0; int s_cnt = 0, s_nreq = 0; logic [31:0] s_a = 0;
  always @(posedge clk) begin
    sram_rvalid <= 1'b0;
    if (sram_req) begin
      s_pend <= 1'b1; s_cnt <= s_nreq % 3; s_a <= sram_addr; s_nreq <= s_nreq + 1;
    end else if (s_pend) begin
      if (s_cnt == 0) begin
        sram_rvalid <= 1'b1; sram_rdata <= sram_fn(s_a); s_pend <= 1'b0;
      end else s_cnt <= s_cnt - 1;
    end
  end

  // Array model and command log
  int f_cnt = 0, n_acc = 0, n_prog = 0, n_pe = 0, n_ea = 0, n_done = 0, row_bad = 0;
  int row_base_cnt = 0; logic row_mode = 0;
  logic [31:0] exp_row = 0, exp_src = 0, last_addr = 0, last_data = 0;
  always @(posedge clk) begin
    int k;
    if (!fa_busy && (fa_prog || fa_erase_pg || fa_erase_all)) begin
      fa_busy <= 1'b1; f_cnt <= n_acc % 4; n_acc <= n_acc + 1;
      last_addr <= fa_addr; last_data <= fa_wdata;
      if (fa_prog) n_prog <= n_prog + 1;
      if (fa_erase_pg) n_pe <= n_pe + 1;
      if (fa_erase_all) n_ea <= n_ea + 1;
      if (row_mode && fa_prog) begin
        k = n_prog - row_base_cnt;
        if (fa_addr != exp_row + 32'(4 * k) || fa_wdata != sram_fn(exp_src + 32'(4 * k)))
          row_bad <= row_bad + 1;
      end
    end else if (fa_busy) begin
      if (f_cnt == 0) fa_busy <= 1'b0; else f_cnt <= f_cnt - 1;
    end
    if (done_evt) n_done <= n_done + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  int ack_busy = 0;

  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] data,
                        input logic [31:0] src, input bit lv, input bit clr_at_done,
                        input bit start_at_done, input bit start_mid);
    int p0, e0, a0, d0, rb0, n, expn;
    bit prot, seen;
    logic [31:0] ea, ed;
    prot = (op == 2'b11) ? (|wp_page) : wp_page[addr[12 +: 2]];
    expn = prot ? 0 : ((op == 2'b01) ? 128 : 1);
    p0 = n_prog; e0 = n_pe; a0 = n_ea; d0 = n_done; rb0 = row_bad;
    row_base_cnt = n_prog; exp_row = addr & ~32'h1FF; exp_src = src & ~32'h3; row_mode = (op == 2'b01);
    case (op)
      2'b00: begin ea = addr & ~32'h3; ed = data; end
      2'b01: begin ea = exp_row + 32'd508; ed = sram_fn(exp_src + 32'd508); end
      2'b10: begin ea = addr & ~32'hFFF; ed = data; end
      default: begin ea = 32'h0; ed = data; end
    endcase
    @(negedge clk);
    op_sel = op; tgt_addr = addr; wdata = data; src_addr = src; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R6 busy after start", 32'(busy), 1);
    n = 0; seen = 0;
    while (!seen && n < 5000) begin
      if (busy && sleep_ack) ack_busy++;
      if (done_evt) begin
        seen = 1; flag_clr = clr_at_done; start = start_at_done; lv_detect = 0;
      end else begin
        lv_detect = lv && (n == 0);
        start = start_mid && (n == 2);
      end
      @(negedge clk); n++;
    end
    start = 0; flag_clr = 0;
    chk(seen, "R7 done_evt seen", 32'(seen), 1);
    chk(busy == 1'b0, "R6 busy low after done", 32'(busy), 0);
    chk(done_flag == 1'b1, "R7 done_flag set", 32'(done_flag), 1);
    chk(n_done - d0 == 1, "R7 single done_evt", 32'(n_done - d0), 1);
    chk(n_prog - p0 == ((op <= 2'b01) ? expn : 0), "R1 R2 R5 program count", 32'(n_prog - p0), 32'((op <= 2'b01) ? expn : 0));
    chk(n_pe - e0 == ((op == 2'b10) ? expn : 0), "R3 R5 page erase count", 32'(n_pe - e0), 32'((op == 2'b10) ? expn : 0));
    chk(n_ea - a0 == ((op == 2'b11) ? expn : 0), "R4 R5 whole erase count", 32'(n_ea - a0), 32'((op == 2'b11) ? expn : 0));
    if (expn > 0) begin
      chk(last_addr == ea, "R1 R2 R3 R4 command address", last_addr, ea);
      if (op <= 2'b01) chk(last_data == ed, "R1 R2 program data", last_data, ed);
    end
    chk(row_bad == rb0, "R2 row address/data sequence", 32'(row_bad - rb0), 0);
    chk(wr_err == (prot | lv), "R5 R8 wr_err", 32'(wr_err), 32'(prot | lv));
    chk(lv_err == lv, "R8 lv_err", 32'(lv_err), 32'(lv));
    row_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done_flag == 0 && wr_err == 0 && lv_err == 0, "R6 R7 reset state",
        {busy, done_flag, wr_err, lv_err}, 0);
    chk(!(fa_prog | fa_erase_pg | fa_erase_all | sram_req), "R11 reset quiet",
        {fa_prog, fa_erase_pg, fa_erase_all, sram_req}, 0);

    // R1 R5: every page against every protect mask
    for (int pg = 0; pg < NP; pg++)
      for (int m = 0; m < 16; m++) begin
        wp_page = 4'(m);
        run_op(2'b00, 32'(pg * 4096 + m * 20 + pg + 1), 32'hC0DE_0000 + 32'(pg * 16 + m), 0, 0, 0, 0, 0);
      end

    // R2: row program, sub-row bits and unaligned source ignored
    wp_page = 4'b0000;
    run_op(2'b01, 32'h0000_2644, 32'h0, 32'h2000_0103, 0, 0, 0, 0);
    wp_page = 4'b0100;
    run_op(2'b01, 32'h0000_2644, 32'h0, 32'h2000_0103, 0, 0, 0, 0);
    wp_page = 4'b1011;
    run_op(2'b01, 32'h0000_2A10, 32'h0, 32'h2000_0F00, 0, 0, 0, 0);

    // R3: page erase on each page, free and protected
    for (int pg = 0; pg < NP; pg++) begin
      wp_page = 4'(~(1 << pg));
      run_op(2'b10, 32'(pg * 4096 + 32'h7F4), 32'h0, 0, 0, 0, 0, 0);
      wp_page = 4'(1 << pg);
      run_op(2'b10, 32'(pg * 4096 + 32'h7F4), 32'h0, 0, 0, 0, 0, 0);
    end

    // R4 R5: whole erase ignores address, refused with any protect bit
    wp_page = 4'b0000;
    run_op(2'b11, 32'h0000_3ABC, 32'h0, 0, 0, 0, 0, 0);
    wp_page = 4'b1000;
    run_op(2'b11, 32'h0000_0000, 32'h0, 0, 0, 0, 0, 0);
    wp_page = 4'b0001;
    run_op(2'b11, 32'h0000_1000, 32'h0, 0, 0, 0, 0, 0);

    // R8: low voltage during a word program
    wp_page = 4'b0000;
    run_op(2'b00, 32'h0000_1234, 32'hDEAD_BEEF, 0, 1, 0, 0, 0);
    // R9: next clean operation clears both error flags
    run_op(2'b00, 32'h0000_0010, 32'h1111_2222, 0, 0, 0, 0, 0);
    chk(wr_err == 0 && lv_err == 0, "R9 errors cleared on new start", {wr_err, lv_err}, 0);

    // R7: clear alone, then clear colliding with completion
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(done_flag == 0, "R7 flag_clr clears", 32'(done_flag), 0);
    run_op(2'b10, 32'h0000_1800, 32'h0, 0, 0, 1, 0, 0);
    chk(done_flag == 1, "R7 set wins over same-cycle clear", 32'(done_flag), 1);

    // R6: start mid-operation and in completion cycle both ignored
    run_op(2'b01, 32'h0000_0200, 32'h0, 32'h2000_4000, 0, 0, 1, 1);
    @(negedge clk);
    chk(busy == 0, "R6 start at completion ignored", 32'(busy), 0);

    // R10: sleep held off while busy
    sleep_req = 1; ack_busy = 0;
    @(negedge clk);
    chk(sleep_ack == 1, "R10 sleep granted when idle", 32'(sleep_ack), 1);
    run_op(2'b00, 32'h0000_0040, 32'h0BAD_F00D, 0, 0, 0, 0, 0);
    chk(ack_busy == 0, "R10 no grant while busy", 32'(ack_busy), 0);
    chk(sleep_ack == 1, "R10 grant after completion", 32'(sleep_ack), 1);
    sleep_req = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule